// File: doc/BRIEF.md
# Register-Mapped General-Purpose Pin Controller

This block manages a bank of general-purpose pins through a small register bus with single-cycle read and write strobes. Each per-pin configuration field has three registers: a set register, a clear register and a status register that reads the field back. Writing a 1 to a bit of the set or clear register changes that bit. Writing a 0 leaves it alone. The fields are pin-controller ownership, output enable, input filter, multi-driver, pull-up, peripheral select, output-write enable and interrupt mask. The filter, multi-driver and peripheral-select fields are stored and read back only; no logic acts on them here.

Software drives output data with set and clear writes, or with a direct write to the data status register. A direct write is masked per bit by the output-write-enable field. Each pin also has a level input and a "known" input. Both pass through a synchronizer. Each owned input pin keeps a level and an undriven flag. The pin-data register returns the pull-up setting for an undriven pin and the level for a driven pin. A level change on an owned input pin latches an interrupt-status bit. The interrupt line is high whenever a latched bit is also unmasked. Reading the status register clears the latched bits.

Top module: `pio_ctrl`

## Requirements
- R1: After reset, the ownership field is all ones and every other field is zero. Every pin is marked undriven, its stored level is zero, the interrupt status is zero and `irq` is low.
- R2: Each field has a set, a clear and a status offset. Ownership uses 0x00/0x04/0x08, output enable 0x10/0x14/0x18, filter 0x20/0x24/0x28, interrupt mask 0x40/0x44/0x48, multi-driver 0x50/0x54/0x58 and output-write enable 0xA0/0xA4/0xA8. A set write ORs `wrData` into the field. A clear write removes the bits that are 1 in `wrData`.
- R3: The pull-up field is enabled at 0x64, disabled at 0x60 and read at 0x68. The peripheral-select field is set at 0x74, cleared at 0x70 and read at 0x78.
- R4: Output data is set at 0x30 and cleared at 0x34, and it reads back at 0x38. `pinOut` always equals the output data and `pinOe` always equals the output-enable field.
- R5: A write to 0x38 replaces only the output-data bits whose output-write-enable bit is 1. All other output-data bits are unchanged.
- R6: `irq` is high exactly when some latched status bit has its mask bit set. Masking and unmasking act on the cycle after the write.
- R7: A read of 0x4C returns the latched status bits and clears them. `irq` is low from the next cycle.
- R8: A pin is eligible when its ownership bit is 1 and its output-enable bit is 0. An eligible pin sets its status bit SYNC_STAGES+1 clock edges after its sampled level changes. The sampled level is `pinIn` AND `pinKnown`. An ineligible pin ignores its inputs and keeps its stored level and undriven flag.
- R9: A read of 0x3C returns, per bit, the pull-up bit when the pin is undriven and the stored level otherwise. An eligible pin is undriven while its synchronized `pinKnown` is 0.
- R10: Reads of unmapped offsets (for example 0x0C) return zero. Writes to unmapped offsets change no field.
- R11: `rdData` carries the read value in the cycle after `rdEn` and is zero in every other cycle.
- R12: A status read that falls on the same edge as a new input event returns the older bits. The new event stays latched afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Single-cycle read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wrData | input | NUM_PINS | Write value, one bit per pin |
| rdData | output | NUM_PINS | Registered read value |
| pinIn | input | NUM_PINS | Pin levels from the pads |
| pinKnown | input | NUM_PINS | 1 where a pin is actively driven from outside |
| pinOut | output | NUM_PINS | Output data to the pads |
| pinOe | output | NUM_PINS | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench uses the default NUM_PINS=32, ADDR_W=9 and SYNC_STAGES=2. With these values the full offset map is reachable, including 0xA0 to 0xA8 and the unmapped 0x1FC, and upper pins such as 16, 20 and 21 can be exercised. The two-stage synchronizer gives a three-edge input-to-status latency. The bench uses that latency to place a status read on the same edge as a fresh event, which tests the coincident case. Read results go into a queue and are compared as the registered read data appears.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int NFIELD = 9;
  // field indices
  localparam int F_PIO = 0;
  localparam int F_OE  = 1;
  localparam int F_FLT = 2;
  localparam int F_OD  = 3;
  localparam int F_IM  = 4;
  localparam int F_MD  = 5;
  localparam int F_PU  = 6;
  localparam int F_SEL = 7;
  localparam int F_OWE = 8;

  localparam int unsigned SET_OFF [NFIELD] = '{'h00, 'h10, 'h20, 'h30, 'h40, 'h50, 'h64, 'h74, 'hA0};
  localparam int unsigned CLR_OFF [NFIELD] = '{'h04, 'h14, 'h24, 'h34, 'h44, 'h54, 'h60, 'h70, 'hA4};
  localparam int unsigned STS_OFF [NFIELD] = '{'h08, 'h18, 'h28, 'h38, 'h48, 'h58, 'h68, 'h78, 'hA8};
  localparam int unsigned PDAT_OFF = 'h3C;
  localparam int unsigned ISR_OFF  = 'h4C;

  typedef enum logic [1:0] {RD_NONE, RD_FIELD, RD_PDAT, RD_ISR} rdKind_e;

  typedef struct packed {
    logic [NFIELD-1:0] setStb;
    logic [NFIELD-1:0] clrStb;
    logic              odWr;
    logic              isrRd;
    logic              rdEn;
    rdKind_e           rdKind;
    logic [3:0]        rdField;
  } ctlStb_t;
endpackage

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctlStb_t           stb
);
  logic [31:0] off;
  assign off = 32'(addr);

  always_comb begin
    stb        = '0;
    stb.rdEn   = rdEn;
    stb.rdKind = RD_NONE;
    for (int f = 0; f < NFIELD; f++) begin
      if (off == SET_OFF[f]) stb.setStb[f] = wrEn;
      if (off == CLR_OFF[f]) stb.clrStb[f] = wrEn;
      if (rdEn && off == STS_OFF[f]) begin
        stb.rdKind  = RD_FIELD;
        stb.rdField = 4'(f);
      end
    end
    // masked direct write of output data (R5)
    if (wrEn && off == STS_OFF[F_OD]) stb.odWr = 1'b1;
    if (rdEn && off == PDAT_OFF) stb.rdKind = RD_PDAT;
    if (rdEn && off == ISR_OFF) begin
      stb.rdKind = RD_ISR;
      stb.isrRd  = 1'b1;
    end
  end
endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStb_t             stb,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] pinKnown,
  output logic [NUM_PINS-1:0] rdData,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0] fieldQ [NFIELD];

  // one set/clear register bank per configuration field (R1, R2, R3, R4, R5)
  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    localparam logic [NUM_PINS-1:0] RST = (f == F_PIO) ? '1 : '0;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 fieldQ[f] <= RST;
      else if (stb.setStb[f])    fieldQ[f] <= fieldQ[f] | wrData;
      else if (stb.clrStb[f])    fieldQ[f] <= fieldQ[f] & ~wrData;
      else if (f == F_OD && stb.odWr)
        fieldQ[f] <= (fieldQ[f] & ~fieldQ[F_OWE]) | (wrData & fieldQ[F_OWE]);
    end
  end

  // input synchronizer
  logic [NUM_PINS-1:0] lvlSh [SYNC_STAGES];
  logic [NUM_PINS-1:0] knSh  [SYNC_STAGES];
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) begin
        lvlSh[s] <= '0;
        knSh[s]  <= '0;
      end
    end else begin
      lvlSh[0] <= pinIn;
      knSh[0]  <= pinKnown;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        lvlSh[s] <= lvlSh[s-1];
        knSh[s]  <= knSh[s-1];
      end
    end
  end

  logic [NUM_PINS-1:0] eligible, sampled, evtVec;
  logic [NUM_PINS-1:0] lvlQ, undrvQ, isrQ;

  assign eligible = fieldQ[F_PIO] & ~fieldQ[F_OE];
  assign sampled  = lvlSh[LAST] & knSh[LAST];
  assign evtVec   = eligible & (sampled ^ lvlQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlQ   <= '0;
      undrvQ <= '1;
      isrQ   <= '0;
    end else begin
      lvlQ   <= (lvlQ & ~eligible) | (sampled & eligible);
      undrvQ <= (undrvQ & ~eligible) | (~knSh[LAST] & eligible);
      isrQ   <= (stb.isrRd ? '0 : isrQ) | evtVec;
    end
  end

  assign irq    = |(isrQ & fieldQ[F_IM]);
  assign pinOut = fieldQ[F_OD];
  assign pinOe  = fieldQ[F_OE];

  // read path
  logic [NUM_PINS-1:0] rdVal;
  always_comb begin
    rdVal = '0;
    unique case (stb.rdKind)
      RD_FIELD: for (int f = 0; f < NFIELD; f++)
                  if (stb.rdField == 4'(f)) rdVal = fieldQ[f];
      RD_PDAT:  rdVal = (lvlQ & ~undrvQ) | (fieldQ[F_PU] & undrvQ);
      RD_ISR:   rdVal = isrQ;
      default:  rdVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= stb.rdEn ? rdVal : '0;
  end

  // assertions
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.setStb, stb.clrStb, stb.odWr}));

  p_owe_masks_direct_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.odWr |=> (((fieldQ[F_OD] ^ $past(fieldQ[F_OD])) & ~$past(fieldQ[F_OWE])) == '0));

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.isrRd |=> ((isrQ & ~$past(evtVec)) == '0));

  p_ineligible_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((((lvlQ ^ $past(lvlQ)) | (undrvQ ^ $past(undrvQ))) & ~$past(eligible)) == '0));

  p_idle_read_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdEn |=> (rdData == '0));

  p_new_event_kept_r12: assert property (@(posedge clk) disable iff (!rstN)
    (|evtVec) |=> ((isrQ & $past(evtVec)) == $past(evtVec)));
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_PINS-1:0] wrData,
  output logic [NUM_PINS-1:0] rdData,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] pinKnown,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irq
);
  ctlStb_t stb;

  pio_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .stb  (stb)
  );

  pio_regs #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (wrData),
    .pinIn    (pinIn),
    .pinKnown (pinKnown),
    .rdData   (rdData),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .irq      (irq)
  );
endmodule

// File: tb/sim_pio_ctrl.sv
`timescale 1ns/1ps
module sim_pio_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wrData = '0, rdData, pinIn = '0, pinKnown = '0, pinOut, pinOe;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pio_ctrl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pinIn(pinIn), .pinKnown(pinKnown),
    .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [8:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [8:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    q.push_back(it);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // monitor: compares registered read data against the scoreboard
  logic rdPend = 1'b0;
  always @(posedge clk) rdPend <= rdEn;
  always @(negedge clk) begin
    item_t it;
    if (rstN) begin
      if (rdPend) begin
        if (q.size() == 0) chk(rdData, 32'hx, "R11 unexpected read data");
        else begin
          it = q.pop_front();
          chk(rdData, it.exp, it.tag);
        end
      end else if (rdData !== '0) begin
        chk(rdData, 32'h0, "R11 idle read data");
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(pinOe, 32'h0, "R1 pinOe");
    chk(pinOut, 32'h0, "R1 pinOut");
    chk({31'h0, irq}, 32'h0, "R1 irq");
    doRead(9'h008, 32'hFFFF_FFFF, "R1 ownership");
    doRead(9'h018, 32'h0, "R1 oe");
    doRead(9'h038, 32'h0, "R1 data");
    doRead(9'h048, 32'h0, "R1 mask");
    doRead(9'h04C, 32'h0, "R1 status");
    doRead(9'h03C, 32'h0, "R1 pin data");
    doRead(9'h0A8, 32'h0, "R1 owe");

    // R2 set/clear fields
    doWrite(9'h004, 32'h0000_000F);
    doRead(9'h008, 32'hFFFF_FFF0, "R2 ownership clear");
    doWrite(9'h000, 32'h0000_0003);
    doRead(9'h008, 32'hFFFF_FFF3, "R2 ownership set");
    doWrite(9'h010, 32'h0000_00F0);
    doRead(9'h018, 32'h0000_00F0, "R2 oe set");
    doWrite(9'h014, 32'h0000_0030);
    doRead(9'h018, 32'h0000_00C0, "R2 oe clear");
    chk(pinOe, 32'h0000_00C0, "R4 pinOe follows oe");
    doWrite(9'h020, 32'h0000_00A5);
    doWrite(9'h024, 32'h0000_0005);
    doRead(9'h028, 32'h0000_00A0, "R2 filter");
    doWrite(9'h050, 32'h0000_0011);
    doRead(9'h058, 32'h0000_0011, "R2 multi-driver");

    // R3 pull-up and select
    doWrite(9'h064, 32'h0000_FF00);
    doWrite(9'h060, 32'h0000_0F00);
    doRead(9'h068, 32'h0000_F000, "R3 pull-up");
    doRead(9'h03C, 32'h0000_F000, "R9 undriven reads pull-up");
    doWrite(9'h074, 32'h0000_0003);
    doWrite(9'h070, 32'h0000_0001);
    doRead(9'h078, 32'h0000_0002, "R3 select");

    // R4 set/clear output data
    doWrite(9'h030, 32'h0000_00C3);
    chk(pinOut, 32'h0000_00C3, "R4 pinOut set");
    doWrite(9'h034, 32'h0000_0041);
    doRead(9'h038, 32'h0000_0082, "R4 data clear");

    // R5 masked direct write
    doWrite(9'h0A0, 32'h0000_000F);
    doRead(9'h0A8, 32'h0000_000F, "R2 owe");
    doWrite(9'h038, 32'hFFFF_FF05);
    chk(pinOut, 32'h0000_0085, "R5 masked write");

    // R10 unmapped
    doWrite(9'h00C, 32'hFFFF_FFFF);
    doWrite(9'h1FC, 32'hFFFF_FFFF);
    doRead(9'h00C, 32'h0, "R10 unmapped read");
    doRead(9'h008, 32'hFFFF_FFF3, "R10 ownership unchanged");
    doRead(9'h018, 32'h0000_00C0, "R10 oe unchanged");
    chk(pinOut, 32'h0000_0085, "R10 data unchanged");

    // R9 pins become driven, level zero: no event
    pinKnown = 32'hFFFF_FFFF;
    repeat (4) @(negedge clk);
    doRead(9'h03C, 32'h0, "R9 driven low");
    doRead(9'h04C, 32'h0, "R8 no event");

    // R8 event on bit16; bit2 (not owned) and bit7 (output) ignored
    pinIn = 32'h0001_0084;
    repeat (4) @(negedge clk);
    chk({31'h0, irq}, 32'h0, "R6 irq masked");
    doWrite(9'h040, 32'h0001_0000);
    chk({31'h0, irq}, 32'h1, "R6 irq unmasked");
    doRead(9'h048, 32'h0001_0000, "R6 mask");
    doRead(9'h03C, 32'h0001_0000, "R9 driven level");
    doRead(9'h04C, 32'h0001_0000, "R8 status");
    chk({31'h0, irq}, 32'h0, "R7 irq after read");
    doRead(9'h04C, 32'h0, "R7 cleared");

    // R6 mask disable with pending status
    doWrite(9'h044, 32'h0001_0000);
    pinIn = 32'h0;
    repeat (4) @(negedge clk);
    chk({31'h0, irq}, 32'h0, "R6 irq disabled");
    doRead(9'h048, 32'h0, "R6 mask cleared");
    doWrite(9'h040, 32'h0001_0000);
    chk({31'h0, irq}, 32'h1, "R6 latched status unmasked");
    doRead(9'h04C, 32'h0001_0000, "R7 falling event");
    chk({31'h0, irq}, 32'h0, "R7 irq low");

    // R9 undriven pin with pull-up
    pinKnown = ~32'h0000_1000;
    repeat (4) @(negedge clk);
    doRead(9'h03C, 32'h0000_1000, "R9 undriven pull-up");
    doRead(9'h04C, 32'h0, "R8 undriven no event");

    // R12 read coincides with new event
    pinIn = 32'h0010_0000;
    repeat (5) @(negedge clk);
    pinIn = 32'h0030_0000;
    repeat (2) @(negedge clk);
    doRead(9'h04C, 32'h0010_0000, "R12 old bits");
    doRead(9'h04C, 32'h0020_0000, "R12 new event kept");

    repeat (3) @(negedge clk);
    if (q.size() != 0) chk(32'(q.size()), 32'h0, "R11 pending reads");
    done = 1'b1;
    summary();
  end
endmodule